// File: doc/BRIEF.md
# Indexed Real-Time Clock with Scratch RAM

This block is a calendar clock that a host reaches through two byte-wide ports. A write to the index port selects a register number. Data-port writes then go to that register, and the read bus always shows the register currently selected. The selected register number stays in place until the next index write, so the host can write the same register several times without selecting it again.

The core holds seven time fields: seconds, minutes, hours, day of week, day of month, month and two-digit year. A prescaler divides a base tick input down to one advance per second. A control register sets how the fields count:
- BCD or plain binary.
- 12-hour or 24-hour format. In 12-hour format bit 7 of the hour byte is the afternoon flag.
- A freeze bit. While it is set, counting stops so that the host can load a consistent time.

The index space also holds three spare alarm bytes (plain storage), a spare control byte, a status byte and a block of general-purpose scratch RAM. A tie-off input reports whether the backup supply is good.

Top module: `rtc_idx_top`

## Requirements
- R1: A write with `wr_is_idx`=1 loads the register number. Every later data-port write goes to that register, and `rd_data` shows it, until the next index write.
- R2: After reset the register number is 0x00. The fields read: seconds (0x00) 0x00, minutes (0x02) 0x00, hours (0x04) 0x00, day of week (0x06) 0x01, day of month (0x07) 0x01, month (0x08) 0x01, year (0x09) 0x00. The mode register (0x0B) reads 0x02.
- R3: In BCD mode (mode bit 2 = 0) each one-second advance increments seconds. Each nibble carries at decimal 9 (0x09→0x10). Seconds roll 0x59→0x00 and carry into minutes, which do the same.
- R4: In binary mode (mode bit 2 = 1) fields count in plain binary (59→0 is 0x3B→0x00). A change of mode bits does not convert stored values; the next advance uses the new mode.
- R5: In 24-hour mode (mode bit 1 = 1) the hour rolls 23→0, and that rollover advances the day fields.
- R6: In 12-hour mode (mode bit 1 = 0) the hour byte holds 1–12 in bits 5:0, with bit 7 set for afternoon. The hour steps 11 AM→12 PM, 12 PM→1 PM, 11 PM→12 AM and 12 AM→1 AM. Only 11 PM→12 AM advances the day.
- R7: Day of month rolls to 1 after the last day of its month: 30 for April, June, September and November, 31 for the others, and 28 for February or 29 when the year is divisible by 4.
- R8: Month rolls 12→1 and advances the year. Year rolls 99→0. Day of week (1–7) rolls 7→1 at each day advance.
- R9: While mode bit 7 is 1, no field advances and the prescaler holds at zero. After the bit is cleared, the first advance comes a full second of base ticks later.
- R10: One advance occurs per TICKS_PER_SEC base ticks. A host write to any time field applies at once and restarts the prescaler, so the next advance needs a full TICKS_PER_SEC base ticks.
- R11: Register 0x0D reads {bat_ok, 7'b0}. Register 0x0C reads 0x00. Writes to both are ignored.
- R12: Scratch RAM at 0x0E–0x7F, the bytes at 0x01, 0x03 and 0x05, and the byte at 0x0A each hold any written value, including 0x00, 0x55 and 0xAA.
- R13: Writes to register numbers 0x80–0xFF change nothing, and reads of them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | One-cycle pulse from the time base, divided down to seconds |
| bat_ok | input | 1 | Backup-supply good flag, shown in the status register |
| wr_en | input | 1 | Host write strobe |
| wr_is_idx | input | 1 | 1: the write goes to the index port; 0: it goes to the data port |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Contents of the selected register |

## Verification
A wrong carry decision shows up at once in the next field up. For example, a wrong month length or a missed leap year gives the wrong day of month at the first midnight that crosses the month end. A wrong afternoon flag appears at the 11→12 hour step. A prescaler that does not restart on a field write, or that keeps counting while frozen, moves the seconds field a fraction of a second early; that shows on the data port within one second of base ticks. A decode that aliases out-of-map or status register numbers corrupts a time field or a RAM byte, which shows on the next read of that register.

// File: rtl/rtc_idx_pkg.sv
package rtc_idx_pkg;

  localparam int NUM_FIELDS = 7;
  localparam int NUM_ALARMS = 3;

  typedef enum logic [2:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_DOW  = 3'd3,
    F_DOM  = 3'd4,
    F_MON  = 3'd5,
    F_YEAR = 3'd6
  } field_e;

  // register numbers the host uses
  localparam logic [7:0] IX_SPARE  = 8'h0A;
  localparam logic [7:0] IX_MODE   = 8'h0B;
  localparam logic [7:0] IX_FLAGS  = 8'h0C;
  localparam logic [7:0] IX_STATUS = 8'h0D;
  localparam int         RAM_BASE  = 14;

  // bit positions in the mode register
  localparam int MB_FREEZE = 7;
  localparam int MB_BIN    = 2;
  localparam int MB_24H    = 1;
  localparam int PM_BIT    = 7;

  localparam logic [7:0] MODE_RESET = 8'h02;

  function automatic logic [7:0] field_index(input int f);
    case (f)
      0:       return 8'h00;
      1:       return 8'h02;
      2:       return 8'h04;
      3:       return 8'h06;
      4:       return 8'h07;
      5:       return 8'h08;
      default: return 8'h09;
    endcase
  endfunction

  function automatic logic [7:0] alarm_index(input int a);
    return 8'(2 * a + 1);
  endfunction

  function automatic logic [7:0] field_reset(input int f);
    return (f == 3 || f == 4 || f == 5) ? 8'h01 : 8'h00;
  endfunction

  // stored byte -> plain number
  function automatic logic [7:0] dec8(input logic [7:0] v, input logic bin);
    return bin ? v : ((8'(v[7:4]) * 8'd10) + 8'(v[3:0]));
  endfunction

  // plain number (0..99) -> stored byte
  function automatic logic [7:0] enc8(input logic [7:0] v, input logic bin);
    return bin ? v : (((v / 8'd10) << 4) | (v % 8'd10));
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'd2:                      return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
      default:                   return 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_idx_port.sv
module rtc_idx_port
  import rtc_idx_pkg::*;
#(
  parameter int RAM_BYTES = 114,
  parameter int RAM_AW    = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_is_idx,
  input  logic [7:0]            wr_data,
  output logic [7:0]            index_q,
  output logic [NUM_FIELDS-1:0] fld_we,
  output logic [NUM_ALARMS-1:0] alarm_we,
  output logic                  spare_we,
  output logic                  mode_we,
  output logic                  ram_we,
  output logic                  ram_hit,
  output logic [RAM_AW-1:0]     ram_addr
);

  localparam logic [7:0] RAM_LO = 8'(RAM_BASE);
  localparam logic [7:0] RAM_HI = 8'(RAM_BASE + RAM_BYTES - 1);

  logic       idx_en;
  logic [7:0] index_d;
  logic       data_wr;

  always_comb begin
    idx_en  = wr_en && wr_is_idx;
    index_d = wr_data;
    data_wr = wr_en && !wr_is_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      index_q <= 8'h00;
    else if (idx_en) index_q <= index_d;
  end

  always_comb begin
    for (int f = 0; f < NUM_FIELDS; f++)
      fld_we[f] = data_wr && (index_q == field_index(f));
    for (int a = 0; a < NUM_ALARMS; a++)
      alarm_we[a] = data_wr && (index_q == alarm_index(a));
    spare_we = data_wr && (index_q == IX_SPARE);
    mode_we  = data_wr && (index_q == IX_MODE);
    ram_hit  = (index_q >= RAM_LO) && (index_q <= RAM_HI);
    ram_we   = data_wr && ram_hit;
    ram_addr = RAM_AW'(index_q - RAM_LO);
  end

endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_idx_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_ALARMS-1:0]      alarm_we,
  input  logic                       spare_we,
  input  logic                       mode_we,
  input  logic [7:0]                 wr_data,
  output logic [NUM_ALARMS-1:0][7:0] alarm_q,
  output logic [7:0]                 spare_q,
  output logic [7:0]                 mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < NUM_ALARMS; a++) alarm_q[a] <= 8'h00;
    end else begin
      for (int a = 0; a < NUM_ALARMS; a++)
        if (alarm_we[a]) alarm_q[a] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        spare_q <= 8'h00;
    else if (spare_we) spare_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_RESET;
    else if (mode_we) mode_q <= wr_data;
  end

endmodule

// File: rtl/rtc_scratch_ram.sv
module rtc_scratch_ram #(
  parameter int DEPTH = 114,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_comb rdata = mem[addr];

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_idx_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       base_tick,
  input  logic                       set_mode,
  input  logic                       bin_mode,
  input  logic                       h24_mode,
  input  logic [NUM_FIELDS-1:0]      fld_we,
  input  logic [7:0]                 wr_data,
  output logic [NUM_FIELDS-1:0][7:0] fld_q,
  output logic                       time_wr
);

  localparam int PRE_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;

  logic pre_last;
  logic sec_evt;

  always_comb time_wr = |fld_we;

  generate
    if (TICKS_PER_SEC > 1) begin : g_pre
      logic [PRE_W-1:0] pre_q, pre_d;
      logic             pre_en;
      always_comb begin
        pre_last = (pre_q == PRE_W'(TICKS_PER_SEC - 1));
        pre_en   = time_wr || set_mode || base_tick;
        pre_d    = (time_wr || set_mode || pre_last) ? '0 : pre_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre_q <= '0;
        else if (pre_en) pre_q <= pre_d;
      end
    end else begin : g_nopre
      always_comb pre_last = 1'b1;
    end
  endgenerate

  always_comb sec_evt = base_tick && pre_last && !set_mode && !time_wr;

  logic [7:0] sec_b, min_b, hr_b, dow_b, dom_b, mon_b, yr_b, mlen;
  logic [7:0] hr_val, hr_next;
  logic       hr_pm, pm_n;
  logic       sec_wrap, min_wrap, day_wrap, dom_wrap, mon_wrap;
  logic [NUM_FIELDS-1:0]      inc;
  logic [NUM_FIELDS-1:0][7:0] nxt;
  logic [NUM_FIELDS-1:0]      fld_en;
  logic [NUM_FIELDS-1:0][7:0] fld_d;

  always_comb begin
    sec_b = dec8(fld_q[F_SEC], bin_mode);
    min_b = dec8(fld_q[F_MIN], bin_mode);
    hr_b  = dec8({2'b00, fld_q[F_HOUR][5:0]}, bin_mode);
    hr_pm = fld_q[F_HOUR][PM_BIT];
    dow_b = dec8(fld_q[F_DOW], bin_mode);
    dom_b = dec8(fld_q[F_DOM], bin_mode);
    mon_b = dec8(fld_q[F_MON], bin_mode);
    yr_b  = dec8(fld_q[F_YEAR], bin_mode);
    mlen  = month_len(mon_b, yr_b);

    sec_wrap = sec_b >= 8'd59;
    min_wrap = min_b >= 8'd59;
    dom_wrap = dom_b >= mlen;
    mon_wrap = mon_b >= 8'd12;

    hr_val   = 8'd0;
    pm_n     = hr_pm;
    day_wrap = 1'b0;
    if (h24_mode) begin
      day_wrap = hr_b >= 8'd23;
      hr_next  = day_wrap ? 8'h00 : enc8(hr_b + 8'd1, bin_mode);
    end else begin
      if (hr_b == 8'd11) begin
        hr_val   = 8'd12;
        pm_n     = !hr_pm;
        day_wrap = hr_pm;
      end else if (hr_b >= 8'd12) begin
        hr_val = 8'd1;
      end else begin
        hr_val = hr_b + 8'd1;
      end
      hr_next = {pm_n, 7'b0} | (enc8(hr_val, bin_mode) & 8'h3F);
    end

    nxt[F_SEC]  = enc8(sec_wrap ? 8'd0 : sec_b + 8'd1, bin_mode);
    nxt[F_MIN]  = enc8(min_wrap ? 8'd0 : min_b + 8'd1, bin_mode);
    nxt[F_HOUR] = hr_next;
    nxt[F_DOW]  = enc8((dow_b >= 8'd7) ? 8'd1 : dow_b + 8'd1, bin_mode);
    nxt[F_DOM]  = enc8(dom_wrap ? 8'd1 : dom_b + 8'd1, bin_mode);
    nxt[F_MON]  = enc8(mon_wrap ? 8'd1 : mon_b + 8'd1, bin_mode);
    nxt[F_YEAR] = enc8((yr_b >= 8'd99) ? 8'd0 : yr_b + 8'd1, bin_mode);

    inc[F_SEC]  = sec_evt;
    inc[F_MIN]  = sec_evt && sec_wrap;
    inc[F_HOUR] = inc[F_MIN] && min_wrap;
    inc[F_DOW]  = inc[F_HOUR] && day_wrap;
    inc[F_DOM]  = inc[F_HOUR] && day_wrap;
    inc[F_MON]  = inc[F_DOM] && dom_wrap;
    inc[F_YEAR] = inc[F_MON] && mon_wrap;

    for (int f = 0; f < NUM_FIELDS; f++) begin
      fld_en[f] = fld_we[f] || inc[f];
      fld_d[f]  = fld_we[f] ? wr_data : nxt[f];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int f = 0; f < NUM_FIELDS; f++) fld_q[f] <= field_reset(f);
    end else begin
      for (int f = 0; f < NUM_FIELDS; f++)
        if (fld_en[f]) fld_q[f] <= fld_d[f];
    end
  end

endmodule

// File: rtl/rtc_idx_top.sv
module rtc_idx_top
  import rtc_idx_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int RAM_BYTES     = 114
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_tick,
  input  logic       bat_ok,
  input  logic       wr_en,
  input  logic       wr_is_idx,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data
);

  localparam int RAM_AW = (RAM_BYTES > 2) ? $clog2(RAM_BYTES) : 1;

  logic [7:0]                 index_q;
  logic [NUM_FIELDS-1:0]      fld_we;
  logic [NUM_ALARMS-1:0]      alarm_we;
  logic                       spare_we, mode_we, ram_we, ram_hit;
  logic [RAM_AW-1:0]          ram_addr;
  logic [NUM_FIELDS-1:0][7:0] fld_q;
  logic [NUM_ALARMS-1:0][7:0] alarm_q;
  logic [7:0]                 spare_q, mode_q, ram_rd, sec_q;
  logic                       set_mode, bin_mode, h24_mode, time_wr;

  rtc_idx_port #(.RAM_BYTES(RAM_BYTES), .RAM_AW(RAM_AW)) u_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_is_idx(wr_is_idx),
    .wr_data(wr_data), .index_q(index_q), .fld_we(fld_we),
    .alarm_we(alarm_we), .spare_we(spare_we), .mode_we(mode_we),
    .ram_we(ram_we), .ram_hit(ram_hit), .ram_addr(ram_addr)
  );

  rtc_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .alarm_we(alarm_we), .spare_we(spare_we),
    .mode_we(mode_we), .wr_data(wr_data), .alarm_q(alarm_q),
    .spare_q(spare_q), .mode_q(mode_q)
  );

  always_comb begin
    set_mode = mode_q[MB_FREEZE];
    bin_mode = mode_q[MB_BIN];
    h24_mode = mode_q[MB_24H];
    sec_q    = fld_q[F_SEC];
  end

  rtc_time_core #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_core (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .set_mode(set_mode),
    .bin_mode(bin_mode), .h24_mode(h24_mode), .fld_we(fld_we),
    .wr_data(wr_data), .fld_q(fld_q), .time_wr(time_wr)
  );

  rtc_scratch_ram #(.DEPTH(RAM_BYTES), .AW(RAM_AW)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(wr_data), .rdata(ram_rd)
  );

  always_comb begin
    rd_data = 8'h00;
    if (ram_hit) begin
      rd_data = ram_rd;
    end else begin
      for (int f = 0; f < NUM_FIELDS; f++)
        if (index_q == field_index(f)) rd_data = fld_q[f];
      for (int a = 0; a < NUM_ALARMS; a++)
        if (index_q == alarm_index(a)) rd_data = alarm_q[a];
      if (index_q == IX_SPARE)  rd_data = spare_q;
      if (index_q == IX_MODE)   rd_data = mode_q;
      if (index_q == IX_FLAGS)  rd_data = 8'h00;
      if (index_q == IX_STATUS) rd_data = {bat_ok, 7'b0};
    end
  end

endmodule

// File: rtl/rtc_idx_checker.sv
module rtc_idx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_is_idx,
  input logic [7:0] wr_data,
  input logic       base_tick,
  input logic       bat_ok,
  input logic [7:0] rd_data,
  input logic [7:0] index_q,
  input logic       set_mode,
  input logic       time_wr,
  input logic [7:0] sec_q
);

  // R1: register number changes only on an index write
  a_r1_index_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_is_idx) |=> $stable(index_q));

  // R1: an index write loads the written byte
  a_r1_index_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_is_idx) |=> (index_q == $past(wr_data)));

  // R9: frozen fields stay put unless the host writes them
  a_r9_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mode && !time_wr) |=> $stable(sec_q));

  // R10: seconds never move without a base tick or a host write
  a_r10_tick_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_tick && !time_wr) |=> $stable(sec_q));

  // R11: status register shows the supply flag only
  a_r11_status_view: assert property (@(posedge clk) disable iff (!rst_n)
    (index_q == 8'h0D) |-> (rd_data == {bat_ok, 7'b0}));

  // R12: a RAM write reads back on the next cycle
  a_r12_ram_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_is_idx && index_q >= 8'h0E && index_q <= 8'h7F)
      |=> (rd_data == $past(wr_data)));

  // R13: out-of-map register numbers read as zero
  a_r13_high_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    index_q[7] |-> (rd_data == 8'h00));

endmodule

bind rtc_idx_top rtc_idx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_is_idx(wr_is_idx),
  .wr_data(wr_data), .base_tick(base_tick), .bat_ok(bat_ok),
  .rd_data(rd_data), .index_q(index_q), .set_mode(set_mode),
  .time_wr(time_wr), .sec_q(sec_q)
);

// File: tb/rtc_idx_top_bench.sv
module rtc_idx_top_bench;

  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rst_n, base_tick, bat_ok, wr_en, wr_is_idx;
  logic [7:0] wr_data, rd_data;
  int         checks = 0, errors = 0;
  bit         done = 0;

  // model of the time fields, held as plain numbers, 24-hour
  int  ms, mm, mh, mdw, mdm, mmo, my;
  bit  mbin, m24;

  always #5 clk = ~clk;

  rtc_idx_top #(.TICKS_PER_SEC(TPS)) u_rtc_idx_top (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .bat_ok(bat_ok),
    .wr_en(wr_en), .wr_is_idx(wr_is_idx), .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic logic [7:0] enc(input int v, input bit bin);
    return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mlen(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hour_enc(input int h, input bit bin, input bit h24);
    int h12;
    if (h24) return enc(h, bin);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return ((h >= 12) ? 8'h80 : 8'h00) | enc(h12, bin);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic put(input logic is_idx, input logic [7:0] v);
    wr_en = 1'b1; wr_is_idx = is_idx; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] ix, input logic [7:0] v);
    put(1'b1, ix); put(1'b0, v);
  endtask

  task automatic rreg(input logic [7:0] ix, output logic [7:0] v);
    put(1'b1, ix); v = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      base_tick = 1'b1; @(negedge clk); base_tick = 1'b0;
    end
  endtask

  task automatic model_step();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0;
          mdw = (mdw == 7) ? 1 : mdw + 1;
          mdm++;
          if (mdm > mlen(mmo, my)) begin
            mdm = 1; mmo++;
            if (mmo == 13) begin mmo = 1; my = (my == 99) ? 0 : my + 1; end
          end
        end
      end
    end
  endtask

  function automatic logic [7:0] mode_byte(input bit frz, input bit bin, input bit h24);
    return {frz, 4'b0, bin, h24, 1'b0};
  endfunction

  task automatic set_time(input int s, input int m, input int h, input int dw,
                          input int dm, input int mo, input int y,
                          input bit bin, input bit h24);
    ms = s; mm = m; mh = h; mdw = dw; mdm = dm; mmo = mo; my = y;
    mbin = bin; m24 = h24;
    wreg(8'h0B, mode_byte(1'b1, bin, h24));
    wreg(8'h00, enc(s, bin));
    wreg(8'h02, enc(m, bin));
    wreg(8'h04, hour_enc(h, bin, h24));
    wreg(8'h06, enc(dw, bin));
    wreg(8'h07, enc(dm, bin));
    wreg(8'h08, enc(mo, bin));
    wreg(8'h09, enc(y, bin));
    wreg(8'h0B, mode_byte(1'b0, bin, h24));
  endtask

  task automatic run_secs(input int n);
    for (int i = 0; i < n; i++) begin
      ticks(TPS); model_step();
    end
  endtask

  task automatic check_time(input string req);
    logic [7:0] v;
    rreg(8'h00, v); check(req, v, enc(ms, mbin));
    rreg(8'h02, v); check(req, v, enc(mm, mbin));
    rreg(8'h04, v); check(req, v, hour_enc(mh, mbin, m24));
    rreg(8'h06, v); check(req, v, enc(mdw, mbin));
    rreg(8'h07, v); check(req, v, enc(mdm, mbin));
    rreg(8'h08, v); check(req, v, enc(mmo, mbin));
    rreg(8'h09, v); check(req, v, enc(my, mbin));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int unsigned seed;
    rst_n = 1'b0; base_tick = 1'b0; bat_ok = 1'b1;
    wr_en = 1'b0; wr_is_idx = 1'b0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state: register 0 selected, fields at their start values
    check("R2", rd_data, 8'h00);
    mbin = 0; m24 = 1; ms = 0; mm = 0; mh = 0; mdw = 1; mdm = 1; mmo = 1; my = 0;
    check_time("R2");
    rreg(8'h0B, v); check("R2", v, 8'h02);

    // R1 index persistence and overwrite
    wreg(8'h20, 8'h5A);
    put(1'b0, 8'h3C);
    check("R1", rd_data, 8'h3C);
    wreg(8'h21, 8'h77);
    rreg(8'h20, v); check("R1", v, 8'h3C);
    rreg(8'h21, v); check("R1", v, 8'h77);

    // R12 scratch RAM patterns and plain storage bytes
    wreg(8'h7E, 8'h00); wreg(8'h7F, 8'h55);
    rreg(8'h7F, v); check("R12", v, 8'h55);
    wreg(8'h7F, 8'hAA);
    rreg(8'h7F, v); check("R12", v, 8'hAA);
    rreg(8'h7E, v); check("R12", v, 8'h00);
    wreg(8'h0E, 8'h11);
    rreg(8'h0E, v); check("R12", v, 8'h11);
    wreg(8'h01, 8'hA1); wreg(8'h03, 8'hB3); wreg(8'h05, 8'hC5); wreg(8'h0A, 8'h6E);
    rreg(8'h01, v); check("R12", v, 8'hA1);
    rreg(8'h03, v); check("R12", v, 8'hB3);
    rreg(8'h05, v); check("R12", v, 8'hC5);
    rreg(8'h0A, v); check("R12", v, 8'h6E);

    // R11 status and flag registers
    wreg(8'h0C, 8'hFF);
    check("R11", rd_data, 8'h00);
    wreg(8'h0D, 8'hFF);
    check("R11", rd_data, 8'h80);
    bat_ok = 1'b0; #1;
    check("R11", rd_data, 8'h00);
    bat_ok = 1'b1; #1;
    check("R11", rd_data, 8'h80);

    // R13 out-of-map accesses: no aliasing into time or RAM
    wreg(8'h80, 8'h99);
    check("R13", rd_data, 8'h00);
    wreg(8'h8E, 8'h99);
    check("R13", rd_data, 8'h00);
    wreg(8'hFF, 8'h42);
    check("R13", rd_data, 8'h00);
    rreg(8'h00, v); check("R13", v, 8'h00);
    rreg(8'h0E, v); check("R13", v, 8'h11);
    rreg(8'h7F, v); check("R13", v, 8'hAA);

    // R3 BCD nibble carry and minute carry
    set_time(9, 0, 10, 3, 15, 6, 20, 0, 1);
    run_secs(1); check_time("R3");
    set_time(58, 59, 10, 3, 15, 6, 20, 0, 1);
    run_secs(3); check_time("R3");

    // R4 binary counting and no conversion on mode change
    set_time(58, 59, 10, 3, 15, 6, 20, 1, 1);
    run_secs(3); check_time("R4");
    set_time(19, 5, 10, 3, 15, 6, 20, 0, 1);
    wreg(8'h0B, mode_byte(1'b0, 1'b1, 1'b1));
    rreg(8'h00, v); check("R4", v, 8'h19);
    ticks(TPS);
    rreg(8'h00, v); check("R4", v, 8'h1A);

    // R5 and R8: end-of-century midnight in both codings
    set_time(58, 59, 23, 7, 31, 12, 99, 0, 1);
    run_secs(3); check_time("R8");
    set_time(58, 59, 23, 7, 31, 12, 99, 1, 1);
    run_secs(3); check_time("R5");

    // R7 month lengths and leap years
    set_time(59, 59, 23, 2, 28, 2, 23, 0, 1); run_secs(1); check_time("R7");
    set_time(59, 59, 23, 2, 28, 2, 24, 0, 1); run_secs(1); check_time("R7");
    set_time(59, 59, 23, 2, 29, 2, 24, 1, 1); run_secs(1); check_time("R7");
    set_time(59, 59, 23, 4, 30, 4, 21, 0, 1); run_secs(1); check_time("R7");
    set_time(59, 59, 23, 5, 31, 1, 21, 1, 1); run_secs(1); check_time("R7");

    // R6 12-hour transitions
    set_time(59, 59, 11, 1, 10, 3, 22, 0, 0); run_secs(1); check_time("R6");
    set_time(59, 59, 12, 1, 10, 3, 22, 0, 0); run_secs(1); check_time("R6");
    set_time(59, 59, 23, 1, 10, 3, 22, 0, 0); run_secs(1); check_time("R6");
    set_time(59, 59, 0, 1, 10, 3, 22, 1, 0);  run_secs(1); check_time("R6");

    // R9 freeze, then resume a full second later
    set_time(30, 10, 5, 2, 2, 2, 2, 0, 1);
    wreg(8'h0B, mode_byte(1'b1, 1'b0, 1'b1));
    ticks(3 * TPS);
    check_time("R9");
    wreg(8'h0B, mode_byte(1'b0, 1'b0, 1'b1));
    ticks(TPS - 1);
    rreg(8'h00, v); check("R9", v, enc(ms, mbin));
    ticks(1); model_step();
    check_time("R9");

    // R10 prescaler length and restart on a field write
    set_time(40, 10, 5, 2, 2, 2, 2, 1, 1);
    ticks(TPS - 1);
    rreg(8'h00, v); check("R10", v, enc(ms, 1));
    ticks(1); model_step();
    rreg(8'h00, v); check("R10", v, enc(ms, 1));
    ticks(2);
    wreg(8'h00, enc(30, 1)); ms = 30;
    ticks(TPS - 1);
    rreg(8'h00, v); check("R10", v, enc(30, 1));
    ticks(1); model_step();
    check_time("R10");

    // randomized times and modes, biased toward rollovers
    seed = $urandom(32'h1F2E3D4C);
    for (int it = 0; it < 16; it++) begin
      int s, m, h, dw, dm, mo, y, n;
      bit b, t;
      b  = 1'($urandom);
      t  = 1'($urandom);
      s  = ($urandom % 2) ? 55 + int'($urandom % 5) : int'($urandom % 60);
      m  = ($urandom % 2) ? 59 : int'($urandom % 60);
      h  = ($urandom % 2) ? 23 : int'($urandom % 24);
      dw = 1 + int'($urandom % 7);
      mo = 1 + int'($urandom % 12);
      y  = int'($urandom % 100);
      dm = ($urandom % 2) ? mlen(mo, y) : 1 + int'($urandom % 28);
      n  = 1 + int'($urandom % 8);
      set_time(s, m, h, dw, dm, mo, y, b, t);
      run_secs(n);
      check_time(t ? "R5" : "R6");
    end

    finish_run();
  end

endmodule